// File: doc/BRIEF.md
# Floating-Point Issue Scheduler and Result Bus Arbiter

This block decides when waiting floating-point operations may start on the two execution units, an adder and a multiplier/divider. It also arbitrates the single result broadcast bus among register loads, adder results and multiplier results. Each unit is modelled as a fixed-latency counter. The latency depends on the operation class and, for multiplies, on whether the operands are normalized. A unit whose result loses arbitration keeps that result and stays busy until it wins the bus.

A separate set of small trackers, one for each operand buffer, produces buffer-free pulses. The timing of each pulse depends on whether the buffer's data arrived before or after its consumer was decoded. The scheduler also flags, one cycle ahead, which unit will own the bus next. A waiting decode can use this flag to finish in the cycle just before the result it needs is broadcast.

Each execution unit runs a state machine with three states. In UNIT_IDLE the unit accepts a start, which moves it to UNIT_EXEC. It leaves UNIT_EXEC for UNIT_RESULT when its counter expires, and it leaves UNIT_RESULT for UNIT_IDLE when its bus request is granted. The bus state machine records who owns the current broadcast cycle: BUS_NONE, BUS_LD, BUS_ADD or BUS_MUL. It is reloaded every cycle from the priority decision. Each buffer tracker has five states: BR_EMPTY, BR_DECODED (decode seen), BR_FILLED (data seen), BR_DELAY (the extra cycle after a late decode) and BR_RELEASE (the free pulse). From BR_RELEASE it always returns to BR_EMPTY.

Top module: `fp_rbus_sched`

## Requirements
- R1: When loads, adder and multiplier request the result bus in the same cycle, the load is broadcast first, then the adder result, then the multiplier result.
- R2: `wake_add` / `wake_mul` is high in the cycle in which that unit's request is granted, and the unit's result is on the bus (bus_valid high) in the following cycle.
- R3: An adder station starts (one-hot `add_start` pulse) only when it is decoded, its data are ready and the adder is idle. Among eligible stations the smallest issue age wins, and on equal ages the lowest index wins.
- R4: The same start rule holds for multiplier stations and `mul_start`, with the multiplier idle as the condition.
- R5: Measured from the cycle of its start pulse, an uncontended result is on the bus after L+1 cycles. L is 2 for the adder. For the multiplier, `mul_op` code 0 (normalized multiply) gives L=3, code 1 (unnormalized multiply) gives 4, code 2 (short divide) gives 9 and code 3 (long divide) gives 12.
- R6: A unit that loses arbitration re-requests every cycle until it is granted. While it waits it starts no new operation, even if a station is eligible.
- R7: `bus_src` encodes the owner of the bus: 0 none, 1 load, 2 adder, 3 multiplier. `bus_tag` carries the issue age of the started operation, or `ld_tag` for a load.
- R8: A load request is broadcast in the next cycle with no unit latency. `cc_valid` is high exactly in the bus cycle of a load whose `ld_test` was set.
- R9: When the fill pulse of a buffer comes in the same cycle as its decode pulse, or after it, `buf_free` pulses for one cycle in the next cycle.
- R10: When the fill pulse of a buffer comes before its decode pulse, `buf_free` pulses for one cycle two cycles after the decode pulse.
- R11: During reset all start, wake, bus, condition and buffer-free outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_dec | input | NA | Adder station holds a decoded operation |
| add_rdy | input | NA | Adder station operands available |
| add_age | input | NA*TAG_W | Issue age per adder station, smaller is older |
| mul_dec | input | NM | Multiplier station holds a decoded operation |
| mul_rdy | input | NM | Multiplier station operands available |
| mul_age | input | NM*TAG_W | Issue age per multiplier station |
| mul_op | input | NM*2 | Operation code per multiplier station (see R5) |
| ld_req | input | 1 | Register load wants the result bus |
| ld_tag | input | TAG_W | Tag of the load |
| ld_test | input | 1 | Load also sets a condition result |
| buf_dec | input | NB | Consumer of a buffer decoded (pulse) |
| buf_fill | input | NB | Data entered a buffer (pulse) |
| add_start | output | NA | One-hot adder start pulse |
| mul_start | output | NM | One-hot multiplier start pulse |
| wake_add | output | 1 | Adder result broadcast next cycle |
| wake_mul | output | 1 | Multiplier result broadcast next cycle |
| bus_valid | output | 1 | Result bus carries a value this cycle |
| bus_tag | output | TAG_W | Tag on the result bus |
| bus_src | output | 2 | Owner of the result bus (see R7) |
| cc_valid | output | 1 | Condition result from a load-and-test |
| buf_free | output | NB | Buffer release pulse |

## Verification
The checker watches on every cycle that start pulses are one-hot and name only decoded, ready stations, and that no unit restarts in the cycle after a start. It also checks that a load request always owns the next bus cycle, that a wake flag is followed by a bus cycle of the matching source, and that the condition strobe appears only during a load broadcast. The age ordering, the exact per-operation latencies, the holding of a losing result while a load takes the bus, and the two buffer-release timings depend on multi-cycle histories. Only the bench's directed and randomized scenarios, compared against its own expected timing, can show them.

// File: rtl/fp_rbus_pkg.sv
package fp_rbus_pkg;

    localparam int LAT_W      = 4;
    localparam int LAT_ADD    = 2;
    localparam int LAT_MUL_N  = 3;
    localparam int LAT_MUL_U  = 4;
    localparam int LAT_DIV_S  = 9;
    localparam int LAT_DIV_L  = 12;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LD   = 2'd1,
        SRC_ADD  = 2'd2,
        SRC_MUL  = 2'd3
    } src_code_e;

    typedef enum logic [1:0] {
        UNIT_IDLE,
        UNIT_EXEC,
        UNIT_RESULT
    } unit_st_e;

    typedef enum logic [1:0] {
        BUS_NONE,
        BUS_LD,
        BUS_ADD,
        BUS_MUL
    } bus_st_e;

    typedef enum logic [2:0] {
        BR_EMPTY,
        BR_DECODED,
        BR_FILLED,
        BR_DELAY,
        BR_RELEASE
    } buf_st_e;

    function automatic logic [LAT_W-1:0] mul_latency(input logic [1:0] op);
        logic [LAT_W-1:0] lat;
        unique case (op)
            2'd0:    lat = LAT_W'(LAT_MUL_N);
            2'd1:    lat = LAT_W'(LAT_MUL_U);
            2'd2:    lat = LAT_W'(LAT_DIV_S);
            default: lat = LAT_W'(LAT_DIV_L);
        endcase
        return lat;
    endfunction

endpackage

// File: rtl/fp_pick.sv
module fp_pick #(
    parameter int N     = 3,
    parameter int TAG_W = 4
) (
    input  logic [N-1:0]       dec,
    input  logic [N-1:0]       rdy,
    input  logic [N*TAG_W-1:0] age,
    input  logic               en,
    output logic [N-1:0]       grant,
    output logic [TAG_W-1:0]   sel_age
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]       elig;
    logic               found;
    logic [TAG_W-1:0]   best;
    logic [IDX_W-1:0]   best_idx;

    assign elig = dec & rdy;

    always_comb begin
        found    = 1'b0;
        best     = '0;
        best_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || (age[i*TAG_W +: TAG_W] < best))) begin
                found    = 1'b1;
                best     = age[i*TAG_W +: TAG_W];
                best_idx = IDX_W'(i);
            end
        end
        for (int i = 0; i < N; i++) begin
            grant[i] = en && found && (best_idx == IDX_W'(i));
        end
    end

    assign sel_age = best;

endmodule

// File: rtl/fp_unit.sv
module fp_unit
    import fp_rbus_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             gnt,
    output logic             idle,
    output logic             req,
    output logic [TAG_W-1:0] tag_out
);
    unit_st_e         st_q, st_d;
    logic [LAT_W-1:0] cnt_q;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= UNIT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tag_q <= '0;
        end else if (st_q == UNIT_IDLE && start) begin
            cnt_q <= lat - LAT_W'(1);
            tag_q <= tag_in;
        end else if (st_q == UNIT_EXEC) begin
            cnt_q <= cnt_q - LAT_W'(1);
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UNIT_IDLE:   if (start) st_d = UNIT_EXEC;
            UNIT_EXEC:   if (cnt_q <= LAT_W'(1)) st_d = UNIT_RESULT;
            UNIT_RESULT: if (gnt) st_d = UNIT_IDLE;
            default:     st_d = UNIT_IDLE;
        endcase
    end

    always_comb begin
        idle    = (st_q == UNIT_IDLE);
        req     = (st_q == UNIT_RESULT);
        tag_out = tag_q;
    end

endmodule

// File: rtl/fp_busarb.sv
module fp_busarb
    import fp_rbus_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_req,
    input  logic [TAG_W-1:0] ld_tag,
    input  logic             ld_test,
    input  logic             add_req,
    input  logic [TAG_W-1:0] add_tag,
    input  logic             mul_req,
    input  logic [TAG_W-1:0] mul_tag,
    output logic             add_gnt,
    output logic             mul_gnt,
    output logic             bus_valid,
    output logic [TAG_W-1:0] bus_tag,
    output logic [1:0]       bus_src,
    output logic             cc_valid
);
    bus_st_e          st_q, st_d;
    logic [TAG_W-1:0] tag_q, tag_d;
    logic             test_q;

    always_comb begin
        if (ld_req)       st_d = BUS_LD;
        else if (add_req) st_d = BUS_ADD;
        else if (mul_req) st_d = BUS_MUL;
        else              st_d = BUS_NONE;
    end

    always_comb begin
        unique case (st_d)
            BUS_LD:  tag_d = ld_tag;
            BUS_ADD: tag_d = add_tag;
            BUS_MUL: tag_d = mul_tag;
            default: tag_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= BUS_NONE;
            tag_q  <= '0;
            test_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            tag_q  <= tag_d;
            test_q <= ld_req && ld_test;
        end
    end

    always_comb begin
        add_gnt   = (st_d == BUS_ADD);
        mul_gnt   = (st_d == BUS_MUL);
        bus_tag   = tag_q;
        cc_valid  = 1'b0;
        unique case (st_q)
            BUS_NONE: begin
                bus_valid = 1'b0;
                bus_src   = SRC_NONE;
            end
            BUS_LD: begin
                bus_valid = 1'b1;
                bus_src   = SRC_LD;
                cc_valid  = test_q;
            end
            BUS_ADD: begin
                bus_valid = 1'b1;
                bus_src   = SRC_ADD;
            end
            default: begin
                bus_valid = 1'b1;
                bus_src   = SRC_MUL;
            end
        endcase
    end

endmodule

// File: rtl/fp_bufrel.sv
module fp_bufrel
    import fp_rbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dec_ev,
    input  logic fill_ev,
    output logic free
);
    buf_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= BR_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BR_EMPTY: begin
                if (fill_ev && dec_ev) st_d = BR_RELEASE;
                else if (dec_ev)       st_d = BR_DECODED;
                else if (fill_ev)      st_d = BR_FILLED;
            end
            BR_DECODED: if (fill_ev) st_d = BR_RELEASE;
            BR_FILLED:  if (dec_ev)  st_d = BR_DELAY;
            BR_DELAY:   st_d = BR_RELEASE;
            BR_RELEASE: st_d = BR_EMPTY;
            default:    st_d = BR_EMPTY;
        endcase
    end

    always_comb begin
        free = (st_q == BR_RELEASE);
    end

endmodule

// File: rtl/fp_rbus_sched.sv
module fp_rbus_sched
    import fp_rbus_pkg::*;
#(
    parameter int NA    = 3,
    parameter int NM    = 2,
    parameter int NB    = 4,
    parameter int TAG_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NA-1:0]       add_dec,
    input  logic [NA-1:0]       add_rdy,
    input  logic [NA*TAG_W-1:0] add_age,
    input  logic [NM-1:0]       mul_dec,
    input  logic [NM-1:0]       mul_rdy,
    input  logic [NM*TAG_W-1:0] mul_age,
    input  logic [NM*2-1:0]     mul_op,
    input  logic                ld_req,
    input  logic [TAG_W-1:0]    ld_tag,
    input  logic                ld_test,
    input  logic [NB-1:0]       buf_dec,
    input  logic [NB-1:0]       buf_fill,
    output logic [NA-1:0]       add_start,
    output logic [NM-1:0]       mul_start,
    output logic                wake_add,
    output logic                wake_mul,
    output logic                bus_valid,
    output logic [TAG_W-1:0]    bus_tag,
    output logic [1:0]          bus_src,
    output logic                cc_valid,
    output logic [NB-1:0]       buf_free
);
    logic             add_idle, mul_idle;
    logic             add_req, mul_req;
    logic [TAG_W-1:0] add_sel_age, mul_sel_age;
    logic [TAG_W-1:0] add_res_tag, mul_res_tag;
    logic [1:0]       mul_sel_op;
    logic [LAT_W-1:0] mul_lat;

    fp_pick #(.N(NA), .TAG_W(TAG_W)) i_add_pick (
        .dec     (add_dec),
        .rdy     (add_rdy),
        .age     (add_age),
        .en      (add_idle),
        .grant   (add_start),
        .sel_age (add_sel_age)
    );

    fp_pick #(.N(NM), .TAG_W(TAG_W)) i_mul_pick (
        .dec     (mul_dec),
        .rdy     (mul_rdy),
        .age     (mul_age),
        .en      (mul_idle),
        .grant   (mul_start),
        .sel_age (mul_sel_age)
    );

    always_comb begin
        mul_sel_op = 2'd0;
        for (int j = 0; j < NM; j++) begin
            if (mul_start[j]) mul_sel_op = mul_op[j*2 +: 2];
        end
        mul_lat = mul_latency(mul_sel_op);
    end

    fp_unit #(.TAG_W(TAG_W)) i_add_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (|add_start),
        .lat     (LAT_W'(LAT_ADD)),
        .tag_in  (add_sel_age),
        .gnt     (wake_add),
        .idle    (add_idle),
        .req     (add_req),
        .tag_out (add_res_tag)
    );

    fp_unit #(.TAG_W(TAG_W)) i_mul_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (|mul_start),
        .lat     (mul_lat),
        .tag_in  (mul_sel_age),
        .gnt     (wake_mul),
        .idle    (mul_idle),
        .req     (mul_req),
        .tag_out (mul_res_tag)
    );

    fp_busarb #(.TAG_W(TAG_W)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_req    (ld_req),
        .ld_tag    (ld_tag),
        .ld_test   (ld_test),
        .add_req   (add_req),
        .add_tag   (add_res_tag),
        .mul_req   (mul_req),
        .mul_tag   (mul_res_tag),
        .add_gnt   (wake_add),
        .mul_gnt   (wake_mul),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_src   (bus_src),
        .cc_valid  (cc_valid)
    );

    for (genvar b = 0; b < NB; b++) begin : g_buf
        fp_bufrel i_rel (
            .clk     (clk),
            .rst_n   (rst_n),
            .dec_ev  (buf_dec[b]),
            .fill_ev (buf_fill[b]),
            .free    (buf_free[b])
        );
    end

endmodule

// File: rtl/fp_rbus_sched_chk.sv
module fp_rbus_sched_chk #(
    parameter int NA    = 3,
    parameter int NM    = 2,
    parameter int NB    = 4,
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NA-1:0]    add_dec,
    input logic [NA-1:0]    add_rdy,
    input logic [NM-1:0]    mul_dec,
    input logic [NM-1:0]    mul_rdy,
    input logic             ld_req,
    input logic [TAG_W-1:0] ld_tag,
    input logic [NA-1:0]    add_start,
    input logic [NM-1:0]    mul_start,
    input logic             wake_add,
    input logic             wake_mul,
    input logic             bus_valid,
    input logic [TAG_W-1:0] bus_tag,
    input logic [1:0]       bus_src,
    input logic             cc_valid,
    input logic [NB-1:0]    buf_free
);
    AST_LOAD_OWNS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> (bus_valid && bus_src == 2'd1 && bus_tag == $past(ld_tag))); // R1

    AST_LOAD_BLOCKS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |-> !(wake_add || wake_mul)); // R1

    AST_ONE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_add && wake_mul)); // R1

    AST_WAKE_ADD_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_add |=> (bus_valid && bus_src == 2'd2)); // R2

    AST_WAKE_MUL_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_mul |=> (bus_valid && bus_src == 2'd3)); // R2

    AST_ADD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(add_start)); // R3

    AST_ADD_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|add_start) |-> ((add_start & ~(add_dec & add_rdy)) == '0)); // R3

    AST_MUL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mul_start)); // R4

    AST_MUL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|mul_start) |-> ((mul_start & ~(mul_dec & mul_rdy)) == '0)); // R4

    AST_ADD_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (|add_start) |=> (add_start == '0)); // R6

    AST_MUL_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (|mul_start) |=> (mul_start == '0)); // R6

    AST_CC_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid |-> (bus_valid && bus_src == 2'd1)); // R8

    AST_FREE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|buf_free) |=> ((buf_free & $past(buf_free)) == '0)); // R9

endmodule

bind fp_rbus_sched fp_rbus_sched_chk #(
    .NA(NA), .NM(NM), .NB(NB), .TAG_W(TAG_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .add_dec   (add_dec),
    .add_rdy   (add_rdy),
    .mul_dec   (mul_dec),
    .mul_rdy   (mul_rdy),
    .ld_req    (ld_req),
    .ld_tag    (ld_tag),
    .add_start (add_start),
    .mul_start (mul_start),
    .wake_add  (wake_add),
    .wake_mul  (wake_mul),
    .bus_valid (bus_valid),
    .bus_tag   (bus_tag),
    .bus_src   (bus_src),
    .cc_valid  (cc_valid),
    .buf_free  (buf_free)
);

// File: tb/test_fp_rbus_sched.sv
`timescale 1ns/100ps
module test_fp_rbus_sched;
    localparam int NA = 3;
    localparam int NM = 2;
    localparam int NB = 4;
    localparam int TW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NA-1:0]   add_dec = '0, add_rdy = '0;
    logic [NA*TW-1:0] add_age = '0;
    logic [NM-1:0]   mul_dec = '0, mul_rdy = '0;
    logic [NM*TW-1:0] mul_age = '0;
    logic [NM*2-1:0] mul_op = '0;
    logic            ld_req = 1'b0, ld_test = 1'b0;
    logic [TW-1:0]   ld_tag = '0;
    logic [NB-1:0]   buf_dec = '0, buf_fill = '0;
    logic [NA-1:0]   add_start;
    logic [NM-1:0]   mul_start;
    logic            wake_add, wake_mul, bus_valid, cc_valid;
    logic [TW-1:0]   bus_tag;
    logic [1:0]      bus_src;
    logic [NB-1:0]   buf_free;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fp_rbus_sched #(.NA(NA), .NM(NM), .NB(NB), .TAG_W(TW)) i_fp_rbus_sched (
        .clk(clk), .rst_n(rst_n),
        .add_dec(add_dec), .add_rdy(add_rdy), .add_age(add_age),
        .mul_dec(mul_dec), .mul_rdy(mul_rdy), .mul_age(mul_age), .mul_op(mul_op),
        .ld_req(ld_req), .ld_tag(ld_tag), .ld_test(ld_test),
        .buf_dec(buf_dec), .buf_fill(buf_fill),
        .add_start(add_start), .mul_start(mul_start),
        .wake_add(wake_add), .wake_mul(wake_mul),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_src(bus_src),
        .cc_valid(cc_valid), .buf_free(buf_free)
    );

    function automatic int add_lat();
        return 2;
    endfunction

    function automatic int mul_lat_exp(input int op);
        case (op)
            0: return 3;
            1: return 4;
            2: return 9;
            default: return 12;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic chk_bus(input logic [1:0] src, input logic [TW-1:0] tag, input string req);
        chk(bus_valid == 1'b1, req, "bus_valid", int'(bus_valid), 1);
        chk(bus_src == src, "R7", "bus_src", int'(bus_src), int'(src));
        chk(bus_tag == tag, "R7", "bus_tag", int'(bus_tag), int'(tag));
    endtask

    task automatic wait_bus(input int n, input logic [1:0] src,
                            input logic [TW-1:0] tag, input string req);
        chk(bus_valid == 1'b0, req, "bus early", int'(bus_valid), 0);
        for (int k = 1; k < n; k++) begin
            tick();
            chk(bus_valid == 1'b0, req, "bus early", int'(bus_valid), 0);
        end
        tick();
        chk_bus(src, tag, req);
    endtask

    task automatic start_add(input int idx, input logic [TW-1:0] age);
        logic [NA-1:0] e;
        add_dec[idx] = 1'b1;
        add_rdy[idx] = 1'b1;
        add_age[idx*TW +: TW] = age;
        #1;
        e = '0;
        e[idx] = 1'b1;
        chk(add_start == e, "R3", "add_start", int'(add_start), int'(e));
        tick();
        add_dec[idx] = 1'b0;
        add_rdy[idx] = 1'b0;
    endtask

    task automatic start_mul(input int idx, input logic [TW-1:0] age, input int op);
        logic [NM-1:0] e;
        mul_dec[idx] = 1'b1;
        mul_rdy[idx] = 1'b1;
        mul_age[idx*TW +: TW] = age;
        mul_op[idx*2 +: 2] = 2'(op);
        #1;
        e = '0;
        e[idx] = 1'b1;
        chk(mul_start == e, "R4", "mul_start", int'(mul_start), int'(e));
        tick();
        mul_dec[idx] = 1'b0;
        mul_rdy[idx] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int exp_at [NB];
        bit dseen [NB];
        bit fseen [NB];
        bit p_req, p_test;
        logic [TW-1:0] p_tag;
        void'($urandom(32'd20240611));

        // reset state
        repeat (3) tick();
        chk(bus_valid == 1'b0, "R11", "bus_valid", int'(bus_valid), 0);
        chk(cc_valid == 1'b0, "R11", "cc_valid", int'(cc_valid), 0);
        chk(buf_free == '0, "R11", "buf_free", int'(buf_free), 0);
        chk(add_start == '0 && mul_start == '0, "R11", "starts", int'(add_start), 0);
        chk(!wake_add && !wake_mul, "R11", "wake", int'(wake_add), 0);
        rst_n = 1'b1;
        tick();

        // uncontended latencies
        start_add(2, 4'd5);
        wait_bus(add_lat(), 2'd2, 4'd5, "R5");
        tick();
        for (int op = 0; op < 4; op++) begin
            start_mul(op % NM, 4'(op + 10), op);
            wait_bus(mul_lat_exp(op), 2'd3, 4'(op + 10), "R5");
            tick();
        end

        // age ordering on the adder
        add_dec = 3'b111; add_rdy = 3'b111;
        add_age = {4'd9, 4'd3, 4'd7};
        #1;
        chk(add_start == 3'b010, "R3", "oldest wins", int'(add_start), 2);
        tick();
        add_dec = '0; add_rdy = '0;
        wait_bus(2, 2'd2, 4'd3, "R3");
        tick();
        add_dec = 3'b111; add_rdy = 3'b111;
        add_age = {4'd9, 4'd4, 4'd4};
        #1;
        chk(add_start == 3'b001, "R3", "tie lowest index", int'(add_start), 1);
        tick();
        add_dec = '0; add_rdy = '0;
        wait_bus(2, 2'd2, 4'd4, "R3");
        tick();
        add_dec = 3'b111; add_rdy = 3'b110;
        add_age = {4'd8, 4'd5, 4'd1};
        #1;
        chk(add_start == 3'b010, "R3", "skip not ready", int'(add_start), 2);
        tick();
        add_dec = 3'b000; add_rdy = 3'b111;
        #1;
        chk(add_start == 3'b000, "R3", "undecoded no start", int'(add_start), 0);
        add_rdy = '0;
        tick();
        tick();
        tick();

        // age ordering on the multiplier
        mul_dec = 2'b11; mul_rdy = 2'b11;
        mul_age = {4'd2, 4'd6};
        mul_op = 4'b0000;
        #1;
        chk(mul_start == 2'b10, "R4", "oldest mul", int'(mul_start), 2);
        tick();
        mul_dec = '0; mul_rdy = '0;
        wait_bus(3, 2'd3, 4'd2, "R4");
        tick();

        // contention: load, adder and multiplier in one cycle
        start_mul(0, 4'd2, 0);
        start_add(1, 4'd6);
        tick();
        ld_req = 1'b1; ld_tag = 4'd9; ld_test = 1'b0;
        add_dec[0] = 1'b1; add_rdy[0] = 1'b1; add_age[3:0] = 4'd1;
        #1;
        chk(!wake_add, "R1", "add yields to load", int'(wake_add), 0);
        chk(!wake_mul, "R1", "mul yields to load", int'(wake_mul), 0);
        chk(add_start == '0, "R6", "held adder no start", int'(add_start), 0);
        tick();
        ld_req = 1'b0;
        chk_bus(2'd1, 4'd9, "R1");
        #1;
        chk(wake_add, "R2", "adder wake before bus", int'(wake_add), 1);
        chk(!wake_mul, "R1", "mul after add", int'(wake_mul), 0);
        chk(add_start == '0, "R6", "held adder still busy", int'(add_start), 0);
        tick();
        chk_bus(2'd2, 4'd6, "R1");
        #1;
        chk(add_start == 3'b001, "R6", "start after release", int'(add_start), 1);
        chk(wake_mul, "R6", "mul re-request granted", int'(wake_mul), 1);
        tick();
        add_dec = '0; add_rdy = '0;
        chk_bus(2'd3, 4'd2, "R1");
        tick();
        chk(bus_valid == 1'b0, "R5", "bus gap", int'(bus_valid), 0);
        tick();
        chk_bus(2'd2, 4'd1, "R5");
        tick();

        // random loads with condition flag
        p_req = 1'b0; p_test = 1'b0; p_tag = '0;
        for (int i = 0; i < 200; i++) begin
            ld_req  = ($urandom % 2) == 0;
            ld_tag  = 4'($urandom);
            ld_test = ($urandom % 3) == 0;
            p_req = ld_req; p_test = ld_test; p_tag = ld_tag;
            tick();
            chk(bus_valid == p_req, "R8", "load bus", int'(bus_valid), int'(p_req));
            if (p_req) begin
                chk(bus_src == 2'd1, "R7", "load src", int'(bus_src), 1);
                chk(bus_tag == p_tag, "R7", "load tag", int'(bus_tag), int'(p_tag));
            end
            chk(cc_valid == (p_req && p_test), "R8", "cc_valid",
                int'(cc_valid), int'(p_req && p_test));
        end
        ld_req = 1'b0; ld_test = 1'b0;
        tick();

        // buffer release, randomized with directed-like coverage
        for (int b = 0; b < NB; b++) begin
            exp_at[b] = -1; dseen[b] = 0; fseen[b] = 0;
        end
        for (int i = 0; i < 600; i++) begin
            for (int b = 0; b < NB; b++) begin
                bit d, f, expv, freed;
                expv = (exp_at[b] == cyc);
                chk(buf_free[b] == expv, (dseen[b] && fseen[b]) ? "R9/R10" : "R9",
                    "buf_free", int'(buf_free[b]), int'(expv));
                freed = expv;
                if (expv) begin
                    exp_at[b] = -1; dseen[b] = 0; fseen[b] = 0;
                end
                d = 1'b0; f = 1'b0;
                if (!freed && exp_at[b] == -1) begin
                    d = (($urandom % 4) == 0) && !dseen[b];
                    f = (($urandom % 4) == 0) && !fseen[b];
                    if (f && (dseen[b] || d)) exp_at[b] = cyc + 1;      // R9
                    else if (d && fseen[b])   exp_at[b] = cyc + 2;      // R10
                    dseen[b] = dseen[b] | d;
                    fseen[b] = fseen[b] | f;
                end
                buf_dec[b] = d;
                buf_fill[b] = f;
            end
            tick();
        end
        buf_dec = '0; buf_fill = '0;

        // directed late-decode case on buffer 0
        tick();
        buf_fill[0] = 1'b1;
        tick();
        buf_fill[0] = 1'b0;
        chk(buf_free[0] == 1'b0, "R10", "no free on early data", int'(buf_free[0]), 0);
        buf_dec[0] = 1'b1;
        tick();
        buf_dec[0] = 1'b0;
        chk(buf_free[0] == 1'b0, "R10", "free delayed", int'(buf_free[0]), 0);
        tick();
        chk(buf_free[0] == 1'b1, "R10", "free two after decode", int'(buf_free[0]), 1);
        tick();
        chk(buf_free[0] == 1'b0, "R10", "single pulse", int'(buf_free[0]), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule